// File: doc/BRIEF.md
# Shared Gray-Count Capture for a Ramp Converter

This block is the digital back end of a single-slope converter that many analog channels share. A start pulse clears one common counter and begins the ramp window. During the window the counter advances once per clock in reflected-binary (Gray) form. Each channel has its own capture register. The register takes the current count on the first rising edge of that channel's comparator bit, so a capture never lands on a code where several bits are changing at once.

When the counter reaches its top value the window closes. Any channel that has not fired is given the full-scale count. The captured Gray words then pass, one channel per cycle, through a single shared Gray-to-binary converter into the output code bank. A one-cycle completion pulse marks the point where every channel holds a valid binary code. The controller is a five-state machine:

- IDLE waits for start.
- RAMP counts and captures.
- FILL forces full scale on silent channels.
- CONV converts one channel per cycle.
- DONE raises the pulse.

The transitions are:

- IDLE→RAMP on start.
- RAMP→FILL when the counter is at its top.
- FILL→CONV unconditionally.
- CONV→DONE after the last channel.
- DONE→IDLE unconditionally.

Top module: `wadc_ramp_digitizer`

## Requirements
- R1: After reset, done_o is low, every code slice of code_o is zero and the controller waits in IDLE.
- R2: The shared count starts at zero on start and changes by at most one bit per clock, so codes on either side of a high-order bit change (for example 511 and 512 with 10 bits) convert exactly.
- R3: If a channel's comparator bit is first sampled high at the k-th clock edge after the edge that took soc_i (k counted from 1), that channel reports binary code k-1.
- R4: After a channel has captured, later rising edges of its comparator within the same conversion do not change its code.
- R5: A comparator bit that is already high when soc_i is taken counts as a rising edge at the first ramp edge, and the channel reports code 0.
- R6: The count stops at 2^CW-1. A channel whose comparator never rises within the window reports 2^CW-1.
- R7: done_o is high for exactly one cycle. It first shows after the (2^CW + NCH + 1)-th clock edge that follows the edge taking soc_i, which is 1029 edges with the defaults.
- R8: soc_i pulses while a conversion is in progress are ignored: neither the timing nor the codes change.
- R9: Channel i's code occupies code_o[i*CW +: CW]. The code bank holds its values outside the conversion phase, regardless of comparator activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soc_i | input | 1 | Start of conversion, one-cycle pulse, taken only in IDLE |
| cmp_i | input | NCH | Comparator outputs, one bit per channel, synchronous to clk |
| code_o | output | NCH*CW | Binary codes, channel i in bits [i*CW +: CW] |
| done_o | output | 1 | One-cycle pulse: all codes valid |

## Verification
The assertions take the comparator bits to be synchronous to clk, with any resynchronisation done upstream. They also take soc_i as a level that is only acted on in IDLE, so the single-bit counter step and the frozen captures hold whatever the comparators do. The stimulus changes every input on the falling clock edge and derives each comparator waveform from a ramp-cycle index. That keeps each expected code an exact number of edges after start. The stimulus includes pulses that drop low and rise again within one window, and start pulses issued mid-ramp.

// File: rtl/wadc_pkg.sv
package wadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_FILL,
        ST_CONV,
        ST_DONE
    } wadc_state_e;

endpackage

// File: rtl/wadc_gray_counter.sv
module wadc_gray_counter #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] gray_q,
    output logic          at_top
);
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    assign bin_nx = bin_q + 1'b1;
    assign at_top = (bin_q == {CW{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (clear) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (step && !at_top) begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // R2: one bit at most changes per advance
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> ($countones(gray_q ^ $past(gray_q)) <= 1));

    // R6: count parks at its top value
    assert_count_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && !clear) |=> $stable(gray_q));

endmodule

// File: rtl/wadc_chan_latch.sv
module wadc_chan_latch #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          window,
    input  logic          fill,
    input  logic          cmp,
    input  logic [CW-1:0] count_g,
    output logic [CW-1:0] code_g,
    output logic          valid
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_g <= '0;
            valid  <= 1'b0;
            prev_q <= 1'b0;
        end else if (arm) begin
            valid  <= 1'b0;
            prev_q <= 1'b0;
        end else if (window) begin
            prev_q <= cmp;
            if (cmp && !prev_q && !valid) begin
                code_g <= count_g;
                valid  <= 1'b1;
            end
        end else if (fill && !valid) begin
            code_g <= count_g;
            valid  <= 1'b1;
        end
    end

    // R4: once captured, the code stays until re-armed
    assert_first_edge_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !arm) |=> $stable(code_g));

endmodule

// File: rtl/wadc_gray2bin.sv
module wadc_gray2bin #(
    parameter int CW = 10
) (
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);
    assign bin_o[CW-1] = gray_i[CW-1];

    for (genvar b = CW - 2; b >= 0; b--) begin : g_bit
        assign bin_o[b] = bin_o[b+1] ^ gray_i[b];
    end

endmodule

// File: rtl/wadc_ramp_digitizer.sv
module wadc_ramp_digitizer
    import wadc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soc_i,
    input  logic [NCH-1:0]    cmp_i,
    output logic [NCH*CW-1:0] code_o,
    output logic              done_o
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [IW-1:0] LAST = IW'(NCH - 1);

    wadc_state_e state_q, state_d;

    logic [IW-1:0]             idx_q;
    logic [NCH-1:0][CW-1:0]    code_q;
    logic [NCH-1:0][CW-1:0]    lat_g;
    logic [NCH-1:0]            lat_valid;
    logic [CW-1:0]             count_g;
    logic [CW-1:0]             sel_bin;
    logic                      at_top;
    logic                      arm;

    assign arm = (state_q == ST_IDLE) && soc_i;

    wadc_gray_counter #(.CW(CW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (arm),
        .step   (state_q == ST_RAMP),
        .gray_q (count_g),
        .at_top (at_top)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        wadc_chan_latch #(.CW(CW)) u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (arm),
            .window  (state_q == ST_RAMP),
            .fill    (state_q == ST_FILL),
            .cmp     (cmp_i[c]),
            .count_g (count_g),
            .code_g  (lat_g[c]),
            .valid   (lat_valid[c])
        );
    end

    wadc_gray2bin #(.CW(CW)) u_g2b (
        .gray_i (lat_g[idx_q]),
        .bin_o  (sel_bin)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (soc_i)        state_d = ST_RAMP;
            ST_RAMP: if (at_top)       state_d = ST_FILL;
            ST_FILL:                   state_d = ST_CONV;
            ST_CONV: if (idx_q == LAST) state_d = ST_DONE;
            ST_DONE:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // output side: conversion index and code bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            code_q <= '0;
        end else begin
            unique case (state_q)
                ST_FILL: idx_q <= '0;
                ST_CONV: begin
                    code_q[idx_q] <= sel_bin;
                    idx_q         <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign code_o = code_q;
    assign done_o = (state_q == ST_DONE);

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: every channel holds a capture before conversion starts
    assert_all_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> (&lat_valid));

    // R6: the window only closes at the top count
    assert_fill_at_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL) |-> at_top);

    // R9: the code bank is written only during conversion
    assert_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CONV) |=> $stable(code_q));

    // R8: a start pulse mid-ramp does not restart the count
    assert_soc_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && soc_i && !at_top) |=> (state_q == ST_RAMP));

endmodule

// File: tb/wadc_ramp_digitizer_bench.sv
module wadc_ramp_digitizer_bench;
    localparam int NCH = 4;
    localparam int CW  = 10;
    localparam int MAXC = (1 << CW) - 1;
    localparam int LAT  = MAXC + NCH + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              soc = 1'b0;
    logic [NCH-1:0]    cmp = '0;
    logic [NCH*CW-1:0] code;
    logic              done;

    int total = 0;
    int bad = 0;
    int done_n;
    logic [NCH*CW-1:0] snap;

    always #10 clk = ~clk;

    wadc_ramp_digitizer #(.NCH(NCH), .CW(CW)) u_wadc_ramp_digitizer (
        .clk    (clk),
        .rst_n  (rst_n),
        .soc_i  (soc),
        .cmp_i  (cmp),
        .code_o (code),
        .done_o (done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_conv(input int on_at[NCH], input int again_at[NCH],
                            input logic [NCH-1:0] pre, input int soc_again);
        int n;
        @(negedge clk);
        soc = 1'b1;
        cmp = pre;
        @(negedge clk);
        soc = 1'b0;
        done_n = -1;
        n = 0;
        while (n < LAT + 20) begin
            if (done) begin
                done_n = n;
                break;
            end
            for (int i = 0; i < NCH; i++)
                cmp[i] = pre[i] ||
                         (on_at[i] >= 0 && n >= on_at[i] && n < on_at[i] + 2) ||
                         (again_at[i] >= 0 && n >= again_at[i]);
            soc = (n == soc_again);
            @(negedge clk);
            n++;
        end
        soc = 1'b0;
        cmp = '0;
        snap = code;
        chk("R7 done latency", done_n, LAT);
        @(negedge clk);
        chk("R7 done width", int'(done), 0);
    endtask

    task automatic check_codes(input string tag, input int exp[NCH]);
        for (int i = 0; i < NCH; i++)
            chk(tag, int'(snap[i*CW +: CW]), exp[i]);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 done at reset", int'(done), 0);
        chk("R1 codes at reset", int'(code == '0), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'(done), 0);
    endtask

    task automatic t_spread;
        run_conv('{5, 100, 700, 1000}, '{-1, -1, -1, -1}, '0, -1);
        check_codes("R3 R9 spread codes", '{5, 100, 700, 1000});
    endtask

    task automatic t_gray_edges;
        run_conv('{511, 512, 255, 256}, '{-1, -1, -1, -1}, '0, -1);
        check_codes("R2 gray boundary codes", '{511, 512, 255, 256});
    endtask

    task automatic t_start_high;
        run_conv('{0, 1, 1022, 1023}, '{-1, -1, -1, -1}, 4'b0001, -1);
        check_codes("R5 low end and top codes", '{0, 1, 1022, 1023});
    endtask

    task automatic t_silent;
        run_conv('{-1, 40, -1, -1}, '{-1, -1, -1, -1}, '0, -1);
        check_codes("R6 full scale", '{MAXC, 40, MAXC, MAXC});
    endtask

    task automatic t_glitch;
        run_conv('{50, 10, 300, 900}, '{200, 20, 301 + 5, 950}, '0, -1);
        check_codes("R4 first edge only", '{50, 10, 300, 900});
    endtask

    task automatic t_soc_busy;
        run_conv('{7, 77, 777, 17}, '{-1, -1, -1, -1}, '0, 300);
        check_codes("R8 soc during ramp", '{7, 77, 777, 17});
    endtask

    task automatic t_idle_hold;
        snap = code;
        for (int k = 0; k < 20; k++) begin
            cmp = NCH'(k);
            @(negedge clk);
        end
        cmp = '0;
        chk("R9 codes hold in idle", int'(code == snap), 1);
        chk("R9 no done in idle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_spread();
        t_gray_edges();
        t_start_high();
        t_silent();
        t_glitch();
        t_soc_busy();
        t_idle_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule